// File: doc/BRIEF.md
# GPIO Output Selector and Drive Controller

This block sits between a simple register bus and a row of general-purpose pads. For every pin, software picks where the output level comes from: either a software-written bit or one of a small set of alternate-function signals. Software also picks a drive mode that decides when the pad output enable is asserted. The modes are never drive, drive only a low level, drive only a high level, and always drive. The two one-sided modes let a pin act as an open-drain or open-source line without any extra logic in the pad.

Pad input levels pass through a two-stage synchronizer. They are read back in a field of the same register that holds the software output bits. The start bit of that field is a parameter, so one layout serves both the 10-pin variant and the 14-pin variant. Source selectors are 5 bits wide and six are packed into each selector register, so up to three selector registers are used. Register reads are registered and return one cycle after the read strobe.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset, every register reads 0, and every pin has `pad_out` = 0 and `pad_oe` = 0.
- R2: The selector for pin n is 5 bits wide. It is held in the register at byte address 0x60 + 4*(n/6), bits [(n%6)*5+4 : (n%6)*5]. Each field reads back exactly as written. Bits that belong to no existing pin, including bits 31:30, read 0.
- R3: The output level of pin n follows its selector value s. With s = 0 it is software bit n. With 1 <= s <= NALT it is `alt_in[s-1]`. With any larger value it is 0.
- R4: The drive mode for pin n is the field at bits [2n+1:2n] of the register at address 0x4C. The encoding is 0 = never drive, 1 = drive only while the pin level is 0, 2 = drive only while the pin level is 1, 3 = always drive. `pad_oe[n]` follows this field.
- R5: Bit n of the register at address 0x48 is the software output bit for pin n. A write to 0x48 does not change the input field.
- R6: Bits [IN_LSB+NPINS-1:IN_LSB] of register 0x48 show the synchronized pad inputs. A level applied just before rising edge k is returned by a read whose strobe is sampled at edge k+2. A read sampled at edge k or k+1 returns the previous level.
- R7: `rdata` is loaded at the rising edge where `rd_en` is high. It holds its value while `rd_en` is low.
- R8: Register bits for pins at or above NPINS read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| alt_in | input | NALT | Alternate-function output sources |
| pad_in | input | NPINS | Pad input levels (asynchronous) |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output enables |

## Verification
The pad outputs are combinational from the stored state, so a bad selector, software bit or mode field shows on `pad_out` or `pad_oe` at the first bus-free sample after the write edge. The packed selector layout is the easiest part to get wrong. A shifted or overlapping field corrupts a neighbouring pin's readback and its pad level in the same cycle, so the bench writes all-ones and mixed patterns and reads each register back. A synchronizer with the wrong depth shows only in timing, so the bench reads the input field at each of the three edges after an input change.

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int NPINS  = 10,
  parameter int IN_LSB = 10,
  parameter int NALT   = 6,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  input  logic [NALT-1:0]   alt_in,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  localparam int SELW = 5;
  localparam int PER_REG = 6;
  localparam int NSEL = 3;
  localparam logic [ADDR_W-1:0] A_IO   = ADDR_W'('h48);
  localparam logic [ADDR_W-1:0] A_DRV  = ADDR_W'('h4C);
  localparam logic [ADDR_W-1:0] A_SEL0 = ADDR_W'('h60);

  logic [NPINS-1:0]      sw_q, s1_q, s2_q;
  logic [2*NPINS-1:0]    drv_q;
  logic [SELW*NPINS-1:0] sel_q;
  logic [NSEL-1:0][31:0] sel_rd;
  logic [31:0]           io_rd;
  logic                  unused_wd;

  assign unused_wd = ^wdata[31:30];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= '0;
      drv_q <= '0;
      sel_q <= '0;
    end else if (wr_en) begin
      if (addr == A_IO)  sw_q  <= wdata[NPINS-1:0];
      if (addr == A_DRV) drv_q <= wdata[2*NPINS-1:0];
      for (int p = 0; p < NPINS; p++)
        if (addr == A_SEL0 + ADDR_W'(4 * (p / PER_REG)))
          sel_q[SELW*p +: SELW] <= wdata[(p % PER_REG)*SELW +: SELW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    sel_rd = '0;
    for (int p = 0; p < NPINS; p++)
      sel_rd[p / PER_REG][(p % PER_REG)*SELW +: SELW] = sel_q[SELW*p +: SELW];
    io_rd = '0;
    io_rd[NPINS-1:0] = sw_q;
    io_rd[IN_LSB +: NPINS] = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_IO:                  rdata <= io_rd;
        A_DRV:                 rdata <= 32'(drv_q);
        A_SEL0:                rdata <= sel_rd[0];
        A_SEL0 + ADDR_W'(4):   rdata <= sel_rd[1];
        A_SEL0 + ADDR_W'(8):   rdata <= sel_rd[2];
        default:               rdata <= '0;
      endcase
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [SELW-1:0] s;
    logic [31:0]     src;
    logic [1:0]      mode;
    assign s    = sel_q[SELW*p +: SELW];
    assign src  = 32'({alt_in, sw_q[p]});
    assign mode = drv_q[2*p +: 2];
    assign pad_out[p] = src[s];
    always_comb begin
      case (mode)
        2'd0: pad_oe[p] = 1'b0;
        2'd1: pad_oe[p] = ~pad_out[p];
        2'd2: pad_oe[p] = pad_out[p];
        default: pad_oe[p] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk #(
  parameter int NPINS  = 10,
  parameter int NALT   = 6,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [31:0]         rdata,
  input logic [NPINS-1:0]    pad_in,
  input logic [NPINS-1:0]    pad_out,
  input logic [NPINS-1:0]    pad_oe,
  input logic [NPINS-1:0]    sw_q,
  input logic [NPINS-1:0]    s2_q,
  input logic [2*NPINS-1:0]  drv_q,
  input logic [5*NPINS-1:0]  sel_q
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  a_r6_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
    age >= 2'd2 |-> s2_q == $past(pad_in, 2));

  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !$past(rd_en)) |-> $stable(rdata));

  a_r5_sw_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !($past(wr_en) && $past(addr) == ADDR_W'('h48))) |-> $stable(sw_q));

  for (genvar p = 0; p < NPINS; p++) begin : g_chk
    a_r3_high_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[5*p +: 5] > 5'(NALT)) |-> !pad_out[p]);
    a_r4_mode_oe: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[p] == ((drv_q[2*p +: 2] == 2'd3) ||
                    (drv_q[2*p +: 2] == 2'd1 && !pad_out[p]) ||
                    (drv_q[2*p +: 2] == 2'd2 && pad_out[p])));
  end
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(.NPINS(NPINS), .NALT(NALT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .sw_q(sw_q), .s2_q(s2_q),
  .drv_q(drv_q), .sel_q(sel_q));

// File: tb/sim_gpio_pin_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_pin_ctrl;
  localparam int NP = 10;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [5:0] alt_in = '0;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_pin_ctrl #(.NPINS(NP), .IN_LSB(10), .NALT(6), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .alt_in(alt_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  // {address, write data, expected readback}
  localparam logic [71:0] VEC [9] = '{
    {8'h60, 32'hFFFF_FFFF, 32'h3FFF_FFFF},  // R2: six fields, bits 31:30 zero
    {8'h64, 32'hFFFF_FFFF, 32'h000F_FFFF},  // R8: only pins 6..9 exist
    {8'h68, 32'hFFFF_FFFF, 32'h0000_0000},  // R8: no pin 12+
    {8'h60, 32'h1234_5678, 32'h1234_5678},  // R2: mixed pattern
    {8'h4C, 32'hFFFF_FFFF, 32'h000F_FFFF},  // R4 R8
    {8'h48, 32'hFFFF_FFFF, 32'h0000_03FF},  // R5 R8: input field stays 0
    {8'h4C, 32'h0000_0000, 32'h0000_0000},  // R4
    {8'h48, 32'h0000_0155, 32'h0000_0155},  // R5
    {8'h64, 32'hC000_0021, 32'h0000_0021}   // R2: pins 6,7 select 1
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1;
    @(posedge clk); @(negedge clk);
    rd_en = 0; d = rdata;
  endtask

  initial begin
    logic [31:0] v, held;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h48, v); chk("R1 io", v, 0);
    rd(8'h4C, v); chk("R1 drv", v, 0);
    rd(8'h60, v); chk("R1 sel0", v, 0);
    rd(8'h64, v); chk("R1 sel1", v, 0);
    chk("R1 pad_out", 32'(pad_out), 0);
    chk("R1 pad_oe", 32'(pad_oe), 0);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk($sformatf("R2/R4/R5/R8 vec%0d", i), v, VEC[i][31:0]);
    end

    // R3: sources; pins 6,7 use alt_in[0]
    wr(8'h60, 0);
    wr(8'h4C, 32'h000F_FFFF);
    alt_in = 6'b000001;
    #1;
    chk("R3 mixed sources", 32'(pad_out), 32'h1D5);
    chk("R4 always drive", 32'(pad_oe), 32'h3FF);
    wr(8'h48, 32'h3FF);
    wr(8'h60, 32'h0000_7CE6);  // pin0=6, pin1=7, pin2=31
    alt_in = 6'b100000;
    #1;
    chk("R3 sel6/7/31", 32'(pad_out[2:0]), 32'h1);
    alt_in = 6'b111111;
    #1;
    chk("R3 out of range zero", 32'(pad_out[2:1]), 0);
    alt_in = 6'b000000;
    #1;
    chk("R3 sel6 follows alt", 32'(pad_out[0]), 0);

    // R4 drive modes on pin 3
    wr(8'h60, 0);
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++) begin
        wr(8'h4C, 32'(m) << 6);
        wr(8'h48, 32'(d) << 3);
        e = (m == 3) || (m == 1 && d == 0) || (m == 2 && d == 1);
        chk($sformatf("R4 mode%0d d%0d oe", m, d), 32'(pad_oe[3]), 32'(e));
        chk($sformatf("R4 mode%0d d%0d out", m, d), 32'(pad_out[3]), 32'(d));
      end

    // R6 synchronizer timing (software bits = 0x008)
    pad_in = 10'h2A5;
    rd(8'h48, v); chk("R6 edge k", v, 32'h008);
    rd(8'h48, v); chk("R6 edge k+1", v, 32'h008);
    rd(8'h48, v); chk("R6 edge k+2", v, 32'h008 | (32'h2A5 << 10));
    wr(8'h48, 32'hFFFF_FFFF);
    rd(8'h48, v); chk("R5 input field not writable", v, 32'h3FF | (32'h2A5 << 10));

    // R7 hold without strobe
    held = rdata;
    pad_in = 10'h155;
    addr = 8'h4C;
    repeat (4) @(negedge clk);
    chk("R7 rdata hold", rdata, held);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule